// File: doc/BRIEF.md
# Self-Gating Register Group

This block is a group of WIDTH storage bits that share a single clock gate. The gate's enable is not written by a designer. Each bit compares the value it holds with the value waiting at its input, and the group asks for a clock edge only when at least one bit would change. The combined request is held in a latch that is open during the low phase of a free-running gater clock. The held value is then ANDed with the functional clock, so a glitch on the request can never reach the clock. When nothing in the group would change, the whole group sees no edge in that cycle.

The request leaves the block as `grp_req_o` so that a parent gater higher in the clock tree can combine it with its siblings. The parent grants the clock back through `parent_en_i`. A wrapping counter records every cycle in which the group's edge was withheld.

A parameter selects how the gate is built:
- **Clock mode** builds the real latch-and-AND gate.
- **Load-enable mode** replaces the gated clock with an equivalent synchronous load enable on the free clock, so the register contents can be compared cycle by cycle against an ungated register.

The register loads on the first clock edge after reset whatever its inputs are, because the held enable is forced high during reset.

Top module: `adaptive_gated_reg_group`

## Requirements
- R1: While `rst_ni` is low, `data_o` reads all zeros and `skip_cnt_o` reads zero.
- R2: `grp_req_o` is 1 exactly when at least one bit position of `data_i` differs from the same position of `data_o`. This holds for a change in any single bit position, checked combinationally in the same cycle.
- R3: On the first rising clock edge after `rst_ni` goes high, `data_o` takes the value of `data_i`. This happens even if `parent_en_i` is 0 and even if no bit differs.
- R4: After the first edge, whenever `parent_en_i` is 1 at a rising edge, `data_o` after that edge equals `data_i` from before it. The contents therefore always match an ungated register that loads on every parent-enabled edge.
- R5: After the first edge, whenever `parent_en_i` is 0 at a rising edge, `data_o` keeps its value, whatever `data_i` is.
- R6: `skip_cnt_o` rises by 1 at every rising edge where the edge was withheld, that is where `parent_en_i` was 0 or no bit differed (the first edge after reset is never withheld). It holds its value when the edge is delivered, and wraps from 2^CNT_W-1 to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Functional clock that the group's gate passes or withholds |
| gclk_i | input | 1 | Free-running gater clock, same period as `clk_i`; the enable latch is open while it is low |
| rst_ni | input | 1 | Active-low asynchronous reset |
| parent_en_i | input | 1 | Clock grant from the parent gating stage |
| data_i | input | WIDTH | Next value offered to the group |
| data_o | output | WIDTH | Stored value of the group |
| grp_req_o | output | 1 | OR of the per-bit change flags, sent to the parent stage |
| skip_cnt_o | output | CNT_W | Wrapping count of withheld clock edges |

## Verification
The bound checker watches every cycle for these properties:
- an idle group or a refused parent grant leaves the stored value unchanged;
- a granted change is loaded on the next edge;
- the first edge after reset always loads;
- the skip counter steps by exactly one or holds.

Only the bench scenarios can show the rest:
- the counter wrapping at its limit;
- a single-bit change being detected in every bit position;
- over long mixed traffic, the gated register never drifts from an ungated register that loads on every granted edge.

// File: rtl/gate_pkg.sv
package gate_pkg;
    typedef enum logic {
        MODE_CLOCK  = 1'b0,
        MODE_LOADEN = 1'b1
    } gate_mode_e;
endpackage

// File: rtl/change_detect.sv
module change_detect #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] cur_i,
    input  logic [WIDTH-1:0] nxt_i,
    output logic [WIDTH-1:0] flag_o,
    output logic             req_o
);
    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        assign flag_o[b] = cur_i[b] ^ nxt_i[b];
    end
    assign req_o = |flag_o;
endmodule

// File: rtl/clock_gater.sv
module clock_gater import gate_pkg::*; #(
    parameter gate_mode_e MODE = MODE_LOADEN
) (
    input  logic clk_i,
    input  logic gclk_i,
    input  logic rst_ni,
    input  logic en_i,
    output logic en_o,
    output logic gclk_o
);
    if (MODE == MODE_CLOCK) begin : g_latch
        logic en_lat;
        always_latch begin
            if (!rst_ni) begin
                en_lat = 1'b1;
            end else if (!gclk_i) begin
                en_lat = en_i;
            end
        end
        assign en_o   = en_lat;
        assign gclk_o = clk_i & en_lat;
    end else begin : g_loaden
        logic unused_gclk;
        assign unused_gclk = gclk_i ^ rst_ni;
        assign en_o        = en_i;
        assign gclk_o      = clk_i;
    end
endmodule

// File: rtl/adaptive_gated_reg_group.sv
module adaptive_gated_reg_group import gate_pkg::*; #(
    parameter int         WIDTH = 8,
    parameter int         CNT_W = 16,
    parameter gate_mode_e MODE  = MODE_LOADEN
) (
    input  logic             clk_i,
    input  logic             gclk_i,
    input  logic             rst_ni,
    input  logic             parent_en_i,
    input  logic [WIDTH-1:0] data_i,
    output logic [WIDTH-1:0] data_o,
    output logic             grp_req_o,
    output logic [CNT_W-1:0] skip_cnt_o
);
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    typedef struct packed {
        logic             first;
        logic [CNT_W-1:0] cnt;
    } ctl_t;

    ctl_t             ctl_d, ctl_q;
    logic [WIDTH-1:0] data_q;
    logic [WIDTH-1:0] bit_flags;
    logic             req;
    logic             en_raw;
    logic             edge_en;
    logic             reg_clk;

    change_detect #(.WIDTH(WIDTH)) u_chg (
        .cur_i  (data_q),
        .nxt_i  (data_i),
        .flag_o (bit_flags),
        .req_o  (req)
    );

    // First edge after reset always loads; afterwards a change plus a grant.
    assign en_raw = ctl_q.first | (parent_en_i & req);

    clock_gater #(.MODE(MODE)) u_gate (
        .clk_i  (clk_i),
        .gclk_i (gclk_i),
        .rst_ni (rst_ni),
        .en_i   (en_raw),
        .en_o   (edge_en),
        .gclk_o (reg_clk)
    );

    always_comb begin
        ctl_d       = ctl_q;
        ctl_d.first = 1'b0;
        if (!edge_en) begin
            ctl_d.cnt = ctl_q.cnt + CNT_ONE;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            ctl_q <= '{first: 1'b1, cnt: '0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    if (MODE == MODE_CLOCK) begin : g_gated_store
        always_ff @(posedge reg_clk or negedge rst_ni) begin
            if (!rst_ni) begin
                data_q <= '0;
            end else begin
                data_q <= data_i;
            end
        end
    end else begin : g_enable_store
        logic [WIDTH-1:0] data_d;
        logic             unused_rclk;
        assign unused_rclk = reg_clk;
        always_comb begin
            data_d = edge_en ? data_i : data_q;
        end
        always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
                data_q <= '0;
            end else begin
                data_q <= data_d;
            end
        end
    end

    assign data_o     = data_q;
    assign grp_req_o  = req;
    assign skip_cnt_o = ctl_q.cnt;
endmodule

module adaptive_gated_reg_group_chk #(
    parameter int WIDTH = 8,
    parameter int CNT_W = 16
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             parent_en_i,
    input logic [WIDTH-1:0] data_i,
    input logic [WIDTH-1:0] data_o,
    input logic             grp_req_o,
    input logic [CNT_W-1:0] skip_cnt_o
);
    logic seen;
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            seen <= 1'b0;
        end else begin
            seen <= 1'b1;
        end
    end

    always @(posedge clk_i) begin
        if (!rst_ni) begin
            AST_RESET_STATE: assert (data_o == '0 && skip_cnt_o == '0); // R1
        end
    end

    AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !grp_req_o |=> $stable(data_o)); // R2

    AST_FIRST_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !seen |=> data_o == $past(data_i)); // R3

    AST_GRANT_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (parent_en_i && grp_req_o) |=> data_o == $past(data_i)); // R4

    AST_PARENT_FREEZE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (seen && !parent_en_i) |=> $stable(data_o)); // R5

    AST_CNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (seen && !(parent_en_i && grp_req_o)) |=>
        skip_cnt_o == CNT_W'($past(skip_cnt_o) + 1'b1)); // R6

    AST_CNT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!seen || (parent_en_i && grp_req_o)) |=> $stable(skip_cnt_o)); // R6
endmodule

bind adaptive_gated_reg_group adaptive_gated_reg_group_chk #(
    .WIDTH(WIDTH),
    .CNT_W(CNT_W)
) u_chk (.*);

// File: tb/adaptive_gated_reg_group_test.sv
`timescale 1ns/1ps
module adaptive_gated_reg_group_test;
    import gate_pkg::*;
    localparam int W  = 8;
    localparam int CW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          parent_en = 1'b0;
    logic [W-1:0]  din = '0;
    logic [W-1:0]  dout;
    logic          req;
    logic [CW-1:0] cnt;

    int checks = 0;
    int fails  = 0;

    // Reference state
    logic [W-1:0] ref_data;
    logic [W-1:0] plain_data;
    int           ref_cnt;
    bit           ref_first;

    always #2 clk = ~clk;

    adaptive_gated_reg_group #(.WIDTH(W), .CNT_W(CW), .MODE(MODE_LOADEN)) uut (
        .clk_i       (clk),
        .gclk_i      (clk),
        .rst_ni      (rst_n),
        .parent_en_i (parent_en),
        .data_i      (din),
        .data_o      (dout),
        .grp_req_o   (req),
        .skip_cnt_o  (cnt)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Called at a falling edge: drive, check the request, pass one rising edge, compare.
    task automatic step(input logic [W-1:0] d, input bit p);
        bit exp_req;
        bit load;
        din       = d;
        parent_en = p;
        #1;
        exp_req = (d != ref_data);
        check(req == exp_req, "R2 group request", req, exp_req);
        @(posedge clk);
        load = ref_first || (p && exp_req);
        if (ref_first || p) plain_data = d;
        if (load) ref_data = d;
        else ref_cnt++;
        ref_first = 1'b0;
        #1;
        check(dout == ref_data, p ? "R4 stored value" : "R5 stored value", dout, ref_data);
        check(dout == plain_data, "R4 ungated reference", dout, plain_data);
        check(cnt == CW'(ref_cnt), "R6 skip count", cnt, CW'(ref_cnt));
        @(negedge clk);
    endtask

    initial begin
        #800000;
        fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [W-1:0] lfsr;
        ref_data   = '0;
        plain_data = '0;
        ref_cnt    = 0;
        ref_first  = 1'b1;
        repeat (3) @(negedge clk);
        check(dout == '0, "R1 reset data", dout, 0);
        check(cnt == '0, "R1 reset count", cnt, 0);

        // R3: first edge loads with parent grant off.
        rst_n = 1'b1;
        step(8'hA5, 1'b0);
        check(dout == 8'hA5, "R3 first edge load", dout, 8'hA5);

        // R6: no change, granted -> withheld edge.
        step(8'hA5, 1'b1);
        step(8'hA5, 1'b1);

        // R2: every single-bit change position triggers a load.
        for (int b = 0; b < W; b++) begin
            step(ref_data ^ (W'(1) << b), 1'b1);
        end

        // R5: parent refuses while data differs.
        step(8'h3C, 1'b0);
        step(8'hFF, 1'b0);
        step(8'h3C, 1'b1);

        // R6: wrap of the counter after many withheld edges.
        for (int i = 0; i < 20; i++) begin
            step(ref_data, i[0]);
        end
        check(cnt == CW'(ref_cnt), "R6 counter wrap", cnt, CW'(ref_cnt));

        // Mixed traffic.
        lfsr = 8'h5B;
        for (int i = 0; i < 300; i++) begin
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            step(lfsr[1:0] == 2'b00 ? lfsr : ref_data, lfsr[6] | lfsr[2]);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule